// File: doc/BRIEF.md
# Linked-Descriptor Block Mover

This engine moves block data between system memory and a peripheral word FIFO. Software writes the address of the first descriptor and picks a direction. It then sets the run bit. The engine works through a chain of descriptors held in memory.

Each descriptor is four 32-bit words. The first word is the flags word. It holds a byte count in bits 15:0, a format bit in bit 30 that must be set, and a final marker in bit 31. The second word is the buffer address and the third word is the address of the next descriptor. The fourth word is fetched and ignored.

For each descriptor the engine moves the byte count as 32-bit words. It then follows the next-descriptor address, and it stops after a descriptor that carries the final marker. The outcome is reported as a 4-bit event code in the channel control register. An interrupt status bit is also set, and that bit drives the interrupt line when the interrupt is enabled.

The memory side is a simple word port. The engine raises `mem_req` and holds the request, with a stable address and write data, until `mem_ready` is sampled high. `mem_err` is valid together with `mem_ready`.

Both peripheral streams follow valid/ready rules, and a word moves on any rising edge where valid and ready are both high:
- On the outgoing stream (memory to peripheral), the engine holds `tx_valid` and `tx_data` unchanged until `tx_ready` accepts the word. The sink may hold off for as long as it likes.
- On the incoming stream (peripheral to memory), `rx_ready` is high only while the engine has room for one word. `rx_last` marks the last word the peripheral has to offer.

Top module: `chain_dma`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and `mem_req`, `tx_valid` and `rx_ready` are low.
- R2: Writing the channel control register (byte offset 0x20) with bit 7 (run) set starts a transfer only when global control (offset 0x00) bit 0 is set. Otherwise the run bit keeps reading 0 and nothing moves. Bit 7 reads 1 from the cycle after a start until the transfer ends.
- R3: Each descriptor at address D is fetched as four reads at D, D+4, D+8 and D+12. A memory request holds its address stable until `mem_ready`.
- R4: With channel control bit 22 clear (memory to peripheral), the words at the buffer address, then +4 and onward, appear in order on `tx_data`. `tx_data` is held while `tx_valid` is high and `tx_ready` is low.
- R5: With bit 22 set (peripheral to memory), incoming words are written to consecutive word addresses starting at the buffer address.
- R6: After a descriptor without the final marker, the engine fetches the descriptor at its next-descriptor address. After one with the marker it ends with event code 0xF (channel control bits 3:0).
- R7: A descriptor whose format bit (flags bit 30) is clear ends the transfer with event code 3, and no data moves for it.
- R8: `mem_err` during a descriptor read ends the transfer with event 3. During a data read or write it ends the transfer with event 4.
- R9: In peripheral-to-memory mode, if `rx_last` arrives on a word that does not complete the final descriptor's byte count, the transfer ends with event 5.
- R10: When a transfer ends, run clears and interrupt status (offset 0x08, bit 0) is set. `irq` equals that bit ANDed with interrupt enable (offset 0x04, bit 0). Writing 1 to status bit 0 clears it.
- R11: The residue register (0x10, bytes left), data address (0x14), next-descriptor register (0x18) and current descriptor pointer (0x1C) show the live values for the active descriptor.
- R12: Writing global control with bit 8 set aborts any transfer and returns every register to its reset value.
- R13: A byte count that is not a multiple of 4 is rounded up to whole words. A count of 0 moves no word and goes straight to the next step of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt line |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the request |
| mem_err | input | 1 | Memory reports an error, valid with `mem_ready` |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Peripheral accepts the outgoing word |
| tx_data | output | 32 | Outgoing word |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Engine accepts an incoming word |
| rx_data | input | 32 | Incoming word |
| rx_last | input | 1 | Incoming word is the peripheral's last |

## Verification
The bench sweeps single-descriptor byte counts from 0 to 12 with ready signals that stall. A design that truncated instead of rounding up would drop the tail word, and one that mishandled a zero count would emit a word or hang.

Chains with non-sequential next-descriptor addresses show whether the engine follows the chain links or simply walks ahead in memory.

Error injection is placed at a descriptor word and at a data word. This catches a design that confuses event codes 3 and 4. An `rx_last` that arrives early catches one that waits forever for more data.

A soft reset issued mid-transfer, and a run issued without enable, show that state is cleared and that no start leaks through.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  // register byte offsets (software-visible layout)
  localparam int OFF_GCTL = 'h00;
  localparam int OFF_IEN  = 'h04;
  localparam int OFF_IST  = 'h08;
  localparam int OFF_HEAD = 'h0C;
  localparam int OFF_RES  = 'h10;
  localparam int OFF_DADR = 'h14;
  localparam int OFF_BRCH = 'h18;
  localparam int OFF_CUR  = 'h1C;
  localparam int OFF_CCR  = 'h20;

  // bit positions decoded by software and by descriptors
  localparam int GCTL_EN_BIT   = 0;
  localparam int GCTL_SRST_BIT = 8;
  localparam int CCR_RUN_BIT   = 7;
  localparam int CCR_DIR_BIT   = 22;
  localparam int FL_FMT_BIT    = 30;
  localparam int FL_FIN_BIT    = 31;

  // outcome codes
  localparam logic [3:0] EV_NONE  = 4'h0;
  localparam logic [3:0] EV_DESC  = 4'h3;
  localparam logic [3:0] EV_DATA  = 4'h4;
  localparam logic [3:0] EV_EARLY = 4'h5;
  localparam logic [3:0] EV_OK    = 4'hF;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RD, S_PUSH, S_PULL, S_WR, S_NEXT
  } walk_state_t;
endpackage

// File: rtl/cdma_walker.sv
module cdma_walker
  import chain_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic          to_mem,
  input  logic [AW-1:0] head,
  output logic          busy,
  output logic          done,
  output logic [3:0]    ev,
  output logic [CW-1:0] resid,
  output logic [AW-1:0] daddr,
  output logic [AW-1:0] branch,
  output logic [AW-1:0] cur,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last
);
  localparam int BPW = DW / 8;
  localparam logic [CW-1:0] STEP = CW'(BPW);
  localparam logic [AW-1:0] ASTEP = AW'(BPW);

  walk_state_t st;
  logic [1:0]    widx;
  logic          fin, fmt, rlast;
  logic [DW-1:0] word;
  logic          tail;
  logic [CW-1:0] resid_nx;

  assign tail     = (resid <= STEP);
  assign resid_nx = tail ? '0 : resid - STEP;
  assign busy     = (st != S_IDLE);

  assign mem_req   = (st == S_FETCH) || (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_FETCH) ? cur + AW'({widx, 2'b00}) : daddr;
  assign mem_wdata = word;
  assign tx_valid  = (st == S_PUSH);
  assign tx_data   = word;
  assign rx_ready  = (st == S_PULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0; fin <= 1'b0; fmt <= 1'b0; rlast <= 1'b0;
      word <= '0; ev <= EV_NONE; done <= 1'b0;
      resid <= '0; daddr <= '0; branch <= '0; cur <= '0;
    end else if (abort) begin
      st <= S_IDLE; widx <= '0; fin <= 1'b0; fmt <= 1'b0; rlast <= 1'b0;
      word <= '0; ev <= EV_NONE; done <= 1'b0;
      resid <= '0; daddr <= '0; branch <= '0; cur <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cur <= head; widx <= '0; ev <= EV_NONE; st <= S_FETCH;
        end
        S_FETCH: if (mem_ready) begin
          if (mem_err) begin
            ev <= EV_DESC; done <= 1'b1; st <= S_IDLE;
          end else begin
            widx <= widx + 2'd1;
            case (widx)
              2'd0: begin
                resid <= mem_rdata[CW-1:0];
                fin   <= mem_rdata[FL_FIN_BIT];
                fmt   <= mem_rdata[FL_FMT_BIT];
              end
              2'd1: daddr  <= mem_rdata[AW-1:0];
              2'd2: branch <= mem_rdata[AW-1:0];
              default: begin
                if (!fmt) begin
                  ev <= EV_DESC; done <= 1'b1; st <= S_IDLE;
                end else if (resid == '0) st <= S_NEXT;
                else st <= to_mem ? S_PULL : S_RD;
              end
            endcase
          end
        end
        S_RD: if (mem_ready) begin
          if (mem_err) begin
            ev <= EV_DATA; done <= 1'b1; st <= S_IDLE;
          end else begin
            word <= mem_rdata; st <= S_PUSH;
          end
        end
        S_PUSH: if (tx_ready) begin
          daddr <= daddr + ASTEP; resid <= resid_nx;
          st <= tail ? S_NEXT : S_RD;
        end
        S_PULL: if (rx_valid) begin
          word <= rx_data; rlast <= rx_last; st <= S_WR;
        end
        S_WR: if (mem_ready) begin
          if (mem_err) begin
            ev <= EV_DATA; done <= 1'b1; st <= S_IDLE;
          end else begin
            daddr <= daddr + ASTEP; resid <= resid_nx;
            if (rlast && !(tail && fin)) begin
              ev <= EV_EARLY; done <= 1'b1; st <= S_IDLE;
            end else st <= tail ? S_NEXT : S_PULL;
          end
        end
        S_NEXT: begin
          if (fin) begin
            ev <= EV_OK; done <= 1'b1; st <= S_IDLE;
          end else begin
            cur <= branch; widx <= '0; st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R6
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ev == EV_OK || ev == EV_DESC || ev == EV_DATA || ev == EV_EARLY));

  // R5
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_ready, mem_req}));
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
  import chain_dma_pkg::*;
#(
  parameter int RW = 6,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          abort,
  output logic          start,
  output logic          to_mem,
  output logic [AW-1:0] head,
  input  logic          busy,
  input  logic          done,
  input  logic [3:0]    ev,
  input  logic [CW-1:0] resid,
  input  logic [AW-1:0] daddr,
  input  logic [AW-1:0] branch,
  input  logic [AW-1:0] cur
);
  logic en, ien, ist;
  logic wr_gctl, wr_ccr, wr_ist;

  assign wr_gctl = reg_we && (reg_addr == RW'(OFF_GCTL));
  assign wr_ccr  = reg_we && (reg_addr == RW'(OFF_CCR));
  assign wr_ist  = reg_we && (reg_addr == RW'(OFF_IST));
  assign abort   = wr_gctl && reg_wdata[GCTL_SRST_BIT];
  assign start   = wr_ccr && reg_wdata[CCR_RUN_BIT] && en && !busy;
  assign irq     = ist && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; ien <= 1'b0; ist <= 1'b0; to_mem <= 1'b0; head <= '0;
    end else if (abort) begin
      en <= 1'b0; ien <= 1'b0; ist <= 1'b0; to_mem <= 1'b0; head <= '0;
    end else begin
      if (wr_gctl) en <= reg_wdata[GCTL_EN_BIT];
      if (reg_we && reg_addr == RW'(OFF_IEN)) ien <= reg_wdata[0];
      if (reg_we && reg_addr == RW'(OFF_HEAD)) head <= reg_wdata[AW-1:0];
      if (wr_ccr && !busy) to_mem <= reg_wdata[CCR_DIR_BIT];
      if (done) ist <= 1'b1;
      else if (wr_ist && reg_wdata[0]) ist <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RW'(OFF_GCTL): reg_rdata[GCTL_EN_BIT] = en;
      RW'(OFF_IEN):  reg_rdata[0] = ien;
      RW'(OFF_IST):  reg_rdata[0] = ist;
      RW'(OFF_HEAD): reg_rdata = 32'(head);
      RW'(OFF_RES):  reg_rdata = 32'(resid);
      RW'(OFF_DADR): reg_rdata = 32'(daddr);
      RW'(OFF_BRCH): reg_rdata = 32'(branch);
      RW'(OFF_CUR):  reg_rdata = 32'(cur);
      RW'(OFF_CCR): begin
        reg_rdata[3:0]         = ev;
        reg_rdata[CCR_RUN_BIT] = busy;
        reg_rdata[CCR_DIR_BIT] = to_mem;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));

  // R10
  ist_set_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
    done |=> ist);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int RW = 6,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last
);
  logic          abort, start, to_mem, busy, done;
  logic [3:0]    ev;
  logic [AW-1:0] head, daddr, branch, cur;
  logic [CW-1:0] resid;

  cdma_regs #(.RW(RW), .AW(AW), .CW(CW)) u_regs (
    .clk, .rst_n, .reg_addr, .reg_we, .reg_wdata, .reg_rdata, .irq,
    .abort, .start, .to_mem, .head, .busy, .done, .ev,
    .resid, .daddr, .branch, .cur
  );

  cdma_walker #(.AW(AW), .DW(DW), .CW(CW)) u_walk (
    .clk, .rst_n, .abort, .start, .to_mem, .head, .busy, .done, .ev,
    .resid, .daddr, .branch, .cur,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ready, .mem_err,
    .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_ready, .rx_data, .rx_last
  );
endmodule

// File: tb/test_chain_dma.sv
`timescale 1ns/1ps
module test_chain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0, mem_err = 1'b0;
  logic        tx_valid, rx_ready;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [31:0] rx_data = '0;

  chain_dma i_chain_dma (.*);

  always #4 clk = ~clk;

  integer checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [0:255];
  logic [31:0] txw [0:63];
  logic [31:0] wla [0:63];
  logic [31:0] wld [0:63];
  logic [31:0] rxd [0:63];
  integer txn = 0, wn = 0, rx_idx = 0, rx_n = 0;
  logic clr_log = 1'b0, stall = 1'b0, tx_hold = 1'b0, err_en = 1'b0, last_en = 1'b0;
  logic [31:0] err_addr = '0;

  // memory, sink and source models driven away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= mem_req && (!stall || (cyc % 3) != 0);
    mem_rdata <= mem[mem_addr[9:2]];
    mem_err   <= mem_req && err_en && (mem_addr == err_addr);
    tx_ready  <= !tx_hold && (!stall || (cyc % 2) == 0);
    rx_valid  <= (rx_idx < rx_n) && (!stall || (cyc % 2) == 1);
    rx_data   <= rxd[rx_idx[5:0]];
    rx_last   <= last_en && (rx_idx == rx_n - 1);
  end

  always @(posedge clk) begin
    if (clr_log) begin
      txn <= 0; wn <= 0; rx_idx <= 0;
    end else begin
      if (tx_valid && tx_ready) begin txw[txn[5:0]] <= tx_data; txn <= txn + 1; end
      if (mem_req && mem_we && mem_ready && !mem_err) begin
        wla[wn[5:0]] <= mem_addr; wld[wn[5:0]] <= mem_wdata; wn <= wn + 1;
      end
      if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_addr = 6'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 6'(a); #1; d = reg_rdata;
  endtask

  task automatic clear_logs();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  task automatic put_desc(input int at, input int cnt, input logic fin, input logic fmt,
                          input logic [31:0] buf_a, input logic [31:0] br);
    mem[at/4]     = {fin, fmt, 14'd0, 16'(cnt)};
    mem[at/4 + 1] = buf_a;
    mem[at/4 + 2] = br;
    mem[at/4 + 3] = 32'hDEAD_0000;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 4000; k++) begin
      rd('h20, v);
      if (!v[7]) break;
    end
  endtask

  task automatic run(input logic [31:0] hd, input logic dir);
    wr('h0C, hd);
    wr('h20, (32'(dir) << 22) | 32'h80);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i) * 32'h0001_0203;
    for (int i = 0; i < 64; i++) rxd[i] = 32'h5A00_0000 + 32'(i) * 32'h0003_0007;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 'h20; a += 4) begin rd(a, v); chk("R1 reg", v, 0); end
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 ports", {29'd0, mem_req, tx_valid, rx_ready}, 0);

    // R2 run without enable
    put_desc('h20, 8, 1'b1, 1'b1, 32'h100, 32'h0);
    clear_logs();
    run(32'h20, 1'b0);
    repeat (10) @(negedge clk);
    rd('h20, v); chk("R2 run ignored", v, 0);
    chk("R2 no data", 32'(txn), 0);

    // R6 R11 three-link chain, memory to peripheral
    wr('h00, 1); wr('h04, 1);
    put_desc('h20, 8, 1'b0, 1'b1, 32'h100, 32'h80);
    put_desc('h80, 5, 1'b0, 1'b1, 32'h180, 32'h50);
    put_desc('h50, 4, 1'b1, 1'b1, 32'h140, 32'h0);
    tx_hold = 1'b1; stall = 1'b1;
    clear_logs();
    run(32'h20, 1'b0);
    rd('h20, v); chk("R2 run set", {31'd0, v[7]}, 1);
    for (int k = 0; k < 200 && !tx_valid; k++) @(negedge clk);
    rd('h10, v); chk("R11 residue", v, 8);
    rd('h14, v); chk("R11 daddr", v, 32'h100);
    rd('h18, v); chk("R11 branch", v, 32'h80);
    rd('h1C, v); chk("R11 cur", v, 32'h20);
    tx_hold = 1'b0;
    wait_idle();
    chk("R6 count", 32'(txn), 5);
    chk("R4 w0", txw[0], mem[64]);  chk("R4 w1", txw[1], mem[65]);
    chk("R13 w2", txw[2], mem[96]); chk("R13 w3", txw[3], mem[97]);
    chk("R6 w4", txw[4], mem[80]);
    rd('h20, v); chk("R6 event", v, 32'h0F);
    rd('h1C, v); chk("R11 cur end", v, 32'h50);
    rd('h14, v); chk("R11 daddr end", v, 32'h144);
    rd('h10, v); chk("R11 residue end", v, 0);
    rd('h08, v); chk("R10 status", v, 1);
    chk("R10 irq", {31'd0, irq}, 1);
    wr('h08, 1);
    rd('h08, v); chk("R10 w1c", v, 0);
    chk("R10 irq low", {31'd0, irq}, 0);

    // R13 sweep of byte counts with interrupt disabled
    wr('h04, 0);
    for (int n = 0; n <= 12; n++) begin
      put_desc('h40, n, 1'b1, 1'b1, 32'h200, 32'h0);
      clear_logs();
      run(32'h40, 1'b0);
      wait_idle();
      chk($sformatf("R13 n=%0d words", n), 32'(txn), 32'((n + 3) / 4));
      for (int k = 0; k < (n + 3) / 4; k++) chk("R13 data", txw[k], mem[128 + k]);
      rd('h20, v); chk("R13 event", v[3:0], 4'hF);
      chk("R10 irq masked", {31'd0, irq}, 0);
      wr('h08, 1);
    end
    wr('h04, 1);

    // R5 peripheral to memory across two links
    put_desc('h30, 8, 1'b0, 1'b1, 32'h300, 32'h90);
    put_desc('h90, 8, 1'b1, 1'b1, 32'h200, 32'h0);
    rx_n = 4; last_en = 1'b1;
    clear_logs();
    run(32'h30, 1'b1);
    wait_idle();
    chk("R5 writes", 32'(wn), 4);
    chk("R5 a0", wla[0], 32'h300); chk("R5 a1", wla[1], 32'h304);
    chk("R5 a2", wla[2], 32'h200); chk("R5 a3", wla[3], 32'h204);
    for (int k = 0; k < 4; k++) chk("R5 data", wld[k], rxd[k]);
    rd('h20, v); chk("R5 event dir", v, 32'h0040_000F);
    wr('h08, 1);

    // R9 early end of incoming data
    put_desc('hA0, 16, 1'b1, 1'b1, 32'h380, 32'h0);
    rx_n = 2;
    clear_logs();
    run(32'hA0, 1'b1);
    wait_idle();
    rd('h20, v); chk("R9 event", v[3:0], 4'h5);
    chk("R9 writes", 32'(wn), 2);
    rd('h10, v); chk("R9 residue", v, 8);
    wr('h08, 1);

    // R7 format bit clear
    put_desc('hB0, 8, 1'b1, 1'b0, 32'h100, 32'h0);
    clear_logs();
    run(32'hB0, 1'b0);
    wait_idle();
    rd('h20, v); chk("R7 event", v[3:0], 4'h3);
    chk("R7 no data", 32'(txn), 0);
    chk("R7 irq", {31'd0, irq}, 1);
    wr('h08, 1);

    // R8 error on descriptor read and on data read
    put_desc('hC0, 8, 1'b1, 1'b1, 32'h100, 32'h0);
    err_en = 1'b1; err_addr = 32'hC4;
    clear_logs();
    run(32'hC0, 1'b0);
    wait_idle();
    rd('h20, v); chk("R8 desc err", v[3:0], 4'h3);
    wr('h08, 1);
    put_desc('hD0, 8, 1'b1, 1'b1, 32'h1C0, 32'h0);
    err_addr = 32'h1C4;
    clear_logs();
    run(32'hD0, 1'b0);
    wait_idle();
    rd('h20, v); chk("R8 data err", v[3:0], 4'h4);
    chk("R8 words before err", 32'(txn), 1);
    err_en = 1'b0;
    wr('h08, 1);

    // R12 soft reset mid-transfer
    tx_hold = 1'b1;
    clear_logs();
    run(32'h20, 1'b0);
    for (int k = 0; k < 200 && !tx_valid; k++) @(negedge clk);
    wr('h00, 32'h100);
    rd('h20, v); chk("R12 ccr", v, 0);
    rd('h00, v); chk("R12 gctl", v, 0);
    rd('h0C, v); chk("R12 head", v, 0);
    rd('h1C, v); chk("R12 cur", v, 0);
    chk("R12 tx idle", {31'd0, tx_valid}, 0);
    tx_hold = 1'b0;
    run(32'h20, 1'b0);
    repeat (10) @(negedge clk);
    rd('h20, v); chk("R2 after reset", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end
endmodule